// File: doc/BRIEF.md
# Token-Ring Dual-Clock FIFO

This block moves data words from one synchronous clock domain to another, unrelated one. It has no binary or Gray-coded pointers. The storage is a closed ring of identical cells. A one-hot put token travels around the ring in the put clock domain and marks the cell that takes the next write. A separate one-hot get token travels in the get clock domain and marks the cell that supplies the next read.

Each cell keeps its own occupancy state as two toggle flags:

- One flag flips on every put into the cell.
- One flag flips on every get from the cell.

Each flag reaches the opposite domain through a two-stage synchronizer. Each domain therefore keeps a view of every cell's occupancy that is late but never optimistic. The put side never sees a cell as free too early, and the get side never sees a cell as holding data too early.

A detector in each domain turns its view into a single flag:

- **Full** is raised unless at least two cells next to each other on the ring look free.
- **Empty** is raised unless at least two cells next to each other look occupied.

This margin covers the synchronizer delay. It has two costs: one cell of capacity is never used, and a single leftover word stays inside until a second word arrives. The valid output is tied high, because gets are gated by the empty flag alone.

Top module: `tr_fifo_top`

## Requirements
- R1: After reset, empty is 1, full is 0, and both tokens sit at cell 0, so the first word put is the first word read.
- R2: A word is accepted on a put clock edge only when put_req is 1 and full is 0. When full is 1, put_req and put_data have no effect on the stored contents or on the order of words read.
- R3: A get is accepted on a get clock edge only when get_req is 1 and empty is 0. get_data takes the word on that same edge, and it holds its value on edges where no get is accepted.
- R4: Words are read in exactly the order they were accepted, including after both tokens have wrapped around the ring many times.
- R5: With no gets, full stays 0 after DEPTH-2 accepted puts and becomes 1 once DEPTH-1 words have been accepted. No more than DEPTH-1 words are ever held.
- R6: Empty is 1 whenever at most one word is held once the synchronizers have settled. A single remaining word is not delivered until a second word arrives.
- R7: get_valid is 1 at all times.
- R8: Gets that free cells cause full to fall again after the synchronizer delay, and new puts then resume.
- R9: Each token is one-hot at all times, and it moves to the next cell in ring order (cell i to cell i+1 modulo DEPTH) exactly on an accepted operation of its own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| put_clk | input | 1 | Put domain clock |
| put_rst_n | input | 1 | Active-low reset, put domain |
| put_req | input | 1 | Request to write put_data |
| put_data | input | WIDTH | Word to write |
| full | output | 1 | Puts are blocked |
| get_clk | input | 1 | Get domain clock |
| get_rst_n | input | 1 | Active-low reset, get domain |
| get_req | input | 1 | Request to read a word |
| get_data | output | WIDTH | Word from the most recent accepted get |
| get_valid | output | 1 | Constant 1 |
| empty | output | 1 | Gets are blocked |

## Verification
The following are checked on every clock edge of each domain:

- The token rules: each token is one-hot and advances one ring position per accepted operation.
- A put never lands on a cell that the put side sees as occupied.
- A get never takes from a cell that the get side sees as free.
- get_data holds its value between accepted gets.

Other behaviour can only be shown by the bench scenarios under two unrelated clocks:

- The end-to-end word order across wrap-around.
- The exact capacity point where full rises.
- The blocking of puts while full.
- The single word left stranded behind the empty flag.
- The recovery of full after reads.

// File: rtl/tr_fifo_pkg.sv
package tr_fifo_pkg;

  localparam int unsigned RING_MAX = 64;

  // Rotate a one-hot token by one position inside a ring of 'depth' cells.
  function automatic logic [RING_MAX-1:0] ring_next(input logic [RING_MAX-1:0] tok,
                                                    input int unsigned depth);
    logic [RING_MAX-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < RING_MAX; i++) begin
      if (i < depth) r[(i + 1) % depth] = tok[i];
    end
    return r;
  endfunction

  // True when two ring-adjacent cells both have their bit set.
  function automatic logic pair_any(input logic [RING_MAX-1:0] v,
                                    input int unsigned depth);
    logic hit;
    hit = 1'b0;
    for (int unsigned i = 0; i < RING_MAX; i++) begin
      if (i < depth) hit = hit | (v[i] & v[(i + 1) % depth]);
    end
    return hit;
  endfunction

endpackage

// File: rtl/tr_fifo_sync2.sv
module tr_fifo_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/tr_fifo_cell.sv
module tr_fifo_cell #(
  parameter int unsigned WIDTH = 16,
  parameter bit          HOME  = 1'b0
) (
  input  logic             put_clk,
  input  logic             put_rst_n,
  input  logic             put_en,
  input  logic [WIDTH-1:0] put_data,
  input  logic             ptok_in,
  output logic             ptok_out,
  output logic             full_pv,
  input  logic             get_clk,
  input  logic             get_rst_n,
  input  logic             get_en,
  input  logic             gtok_in,
  output logic             gtok_out,
  output logic             full_gv,
  output logic [WIDTH-1:0] rd_data
);
  logic             ptok_q;
  logic             gtok_q;
  logic             pflag_q;
  logic             gflag_q;
  logic             pflag_s;
  logic             gflag_s;
  logic [WIDTH-1:0] data_q;
  logic             cell_put;
  logic             cell_get;

  assign cell_put = put_en & ptok_q;
  assign cell_get = get_en & gtok_q;

  // put domain: token stage, data register, put toggle flag
  always_ff @(posedge put_clk or negedge put_rst_n) begin
    if (!put_rst_n) begin
      ptok_q  <= HOME;
      pflag_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (put_en) ptok_q <= ptok_in;
      if (cell_put) begin
        data_q  <= put_data;
        pflag_q <= ~pflag_q;
      end
    end
  end

  // get domain: token stage, get toggle flag
  always_ff @(posedge get_clk or negedge get_rst_n) begin
    if (!get_rst_n) begin
      gtok_q  <= HOME;
      gflag_q <= 1'b0;
    end else begin
      if (get_en) gtok_q <= gtok_in;
      if (cell_get) gflag_q <= ~gflag_q;
    end
  end

  tr_fifo_sync2 u_g2p (.clk(put_clk), .rst_n(put_rst_n), .d(gflag_q), .q(gflag_s));
  tr_fifo_sync2 u_p2g (.clk(get_clk), .rst_n(get_rst_n), .d(pflag_q), .q(pflag_s));

  // differing flags mean the cell holds a word; each side sees a late copy
  assign full_pv  = pflag_q ^ gflag_s;
  assign full_gv  = pflag_s ^ gflag_q;
  assign ptok_out = ptok_q;
  assign gtok_out = gtok_q;
  assign rd_data  = data_q & {WIDTH{gtok_q}};
endmodule

// File: rtl/tr_fifo_ctrl.sv
module tr_fifo_ctrl #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0] usable,
  input  logic             req,
  output logic             blocked,
  output logic             en
);
  import tr_fifo_pkg::*;

  logic pair_ok;

  assign pair_ok = pair_any(RING_MAX'(usable), DEPTH);
  assign blocked = ~pair_ok;
  assign en      = req & pair_ok;
endmodule

// File: rtl/tr_fifo_top.sv
module tr_fifo_top #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic             put_clk,
  input  logic             put_rst_n,
  input  logic             put_req,
  input  logic [WIDTH-1:0] put_data,
  output logic             full,
  input  logic             get_clk,
  input  logic             get_rst_n,
  input  logic             get_req,
  output logic [WIDTH-1:0] get_data,
  output logic             get_valid,
  output logic             empty
);
  logic [DEPTH-1:0] ptok;
  logic [DEPTH-1:0] gtok;
  logic [DEPTH-1:0] full_pv;
  logic [DEPTH-1:0] full_gv;
  logic [DEPTH-1:0] empty_pv;
  logic [WIDTH-1:0] rd_bus [DEPTH];
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] get_data_q;
  logic             put_fire;
  logic             get_fire;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int unsigned PREV = (i + DEPTH - 1) % DEPTH;
    tr_fifo_cell #(.WIDTH(WIDTH), .HOME(i == 0)) u_cell (
      .put_clk  (put_clk),
      .put_rst_n(put_rst_n),
      .put_en   (put_fire),
      .put_data (put_data),
      .ptok_in  (ptok[PREV]),
      .ptok_out (ptok[i]),
      .full_pv  (full_pv[i]),
      .get_clk  (get_clk),
      .get_rst_n(get_rst_n),
      .get_en   (get_fire),
      .gtok_in  (gtok[PREV]),
      .gtok_out (gtok[i]),
      .full_gv  (full_gv[i]),
      .rd_data  (rd_bus[i])
    );
  end

  assign empty_pv = ~full_pv;

  tr_fifo_ctrl #(.DEPTH(DEPTH)) u_put_ctrl (
    .usable(empty_pv), .req(put_req), .blocked(full), .en(put_fire));

  tr_fifo_ctrl #(.DEPTH(DEPTH)) u_get_ctrl (
    .usable(full_gv), .req(get_req), .blocked(empty), .en(get_fire));

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++) rd_word = rd_word | rd_bus[i];
  end

  always_ff @(posedge get_clk or negedge get_rst_n) begin
    if (!get_rst_n) get_data_q <= '0;
    else if (get_fire) get_data_q <= rd_word;
  end

  assign get_data  = get_data_q;
  assign get_valid = 1'b1;
endmodule

// File: rtl/tr_fifo_chk.sv
module tr_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input logic             put_clk,
  input logic             put_rst_n,
  input logic             get_clk,
  input logic             get_rst_n,
  input logic             put_fire,
  input logic             get_fire,
  input logic [DEPTH-1:0] ptok,
  input logic [DEPTH-1:0] gtok,
  input logic [DEPTH-1:0] full_pv,
  input logic [DEPTH-1:0] full_gv,
  input logic [WIDTH-1:0] get_data
);
  import tr_fifo_pkg::*;

  p_no_overflow_r2: assert property (@(posedge put_clk) disable iff (!put_rst_n)
    put_fire |-> ((ptok & full_pv) == '0));

  p_no_underflow_r3: assert property (@(posedge get_clk) disable iff (!get_rst_n)
    get_fire |-> ((gtok & full_gv) != '0));

  p_get_hold_r3: assert property (@(posedge get_clk) disable iff (!get_rst_n)
    !get_fire |=> $stable(get_data));

  p_ptok_onehot_r9: assert property (@(posedge put_clk) disable iff (!put_rst_n)
    $countones(ptok) == 1);

  p_gtok_onehot_r9: assert property (@(posedge get_clk) disable iff (!get_rst_n)
    $countones(gtok) == 1);

  p_ptok_step_r9: assert property (@(posedge put_clk) disable iff (!put_rst_n)
    put_fire |=> (RING_MAX'(ptok) == ring_next(RING_MAX'($past(ptok)), DEPTH)));

  p_gtok_step_r9: assert property (@(posedge get_clk) disable iff (!get_rst_n)
    get_fire |=> (RING_MAX'(gtok) == ring_next(RING_MAX'($past(gtok)), DEPTH)));

  p_ptok_still_r9: assert property (@(posedge put_clk) disable iff (!put_rst_n)
    !put_fire |=> $stable(ptok));
endmodule

bind tr_fifo_top tr_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .put_clk(put_clk), .put_rst_n(put_rst_n), .get_clk(get_clk), .get_rst_n(get_rst_n),
  .put_fire(put_fire), .get_fire(get_fire), .ptok(ptok), .gtok(gtok),
  .full_pv(full_pv), .full_gv(full_gv), .get_data(get_data));

// File: tb/tb_tr_fifo_top.sv
`timescale 1ns/1ps
module tb_tr_fifo_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned WIDTH = 16;

  logic             put_clk = 1'b0;
  logic             get_clk = 1'b0;
  logic             put_rst_n = 1'b0;
  logic             get_rst_n = 1'b0;
  logic             put_req = 1'b0;
  logic [WIDTH-1:0] put_data = '0;
  logic             get_req = 1'b0;
  logic             full;
  logic             empty;
  logic             get_valid;
  logic [WIDTH-1:0] get_data;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [WIDTH-1:0] expq[$];
  int  put_mode = 0;       // 0 idle, 1 budgeted, 2 random
  int  put_budget = 0;
  int  get_mode = 0;       // 0 idle, 1 always, 2 random
  int  received = 0;
  logic [WIDTH-1:0] next_word = 16'h1000;
  bit  finished = 1'b0;

  always #2.5  put_clk = ~put_clk;   // 200 MHz
  always #3.65 get_clk = ~get_clk;

  tr_fifo_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .put_clk(put_clk), .put_rst_n(put_rst_n), .put_req(put_req), .put_data(put_data),
    .full(full), .get_clk(get_clk), .get_rst_n(get_rst_n), .get_req(get_req),
    .get_data(get_data), .get_valid(get_valid), .empty(empty));

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: inputs change at put falling edge; full is stable there
  always @(negedge put_clk) begin
    if (put_rst_n && put_mode != 0) begin
      put_req  = (put_mode == 1) ? (put_budget > 0) : ($urandom % 3 != 0);
      put_data = next_word;
      if (put_req && !full) begin
        expq.push_back(next_word);
        next_word = next_word + 16'd1;
        if (put_mode == 1) put_budget--;
        check("R5", expq.size() <= DEPTH - 1, expq.size(), DEPTH - 1);
      end
    end else begin
      put_req = 1'b0;
    end
  end

  // monitor: compare the word of the previous accepted get, then issue the next
  bit pend = 1'b0;
  always @(negedge get_clk) begin
    check("R7", get_valid == 1'b1, get_valid, 1);
    if (pend) begin
      if (expq.size() == 0) check("R3", 1'b0, get_data, 0);
      else begin
        logic [WIDTH-1:0] e;
        e = expq.pop_front();
        check("R4", get_data == e, get_data, e);
        received++;
      end
    end
    if (get_rst_n) begin
      get_req = (get_mode == 1) ? 1'b1 : (get_mode == 2) ? ($urandom % 2 == 1) : 1'b0;
    end else get_req = 1'b0;
    pend = get_req && !empty;
  end

  task automatic wait_put(input int n);
    repeat (n) @(negedge put_clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    wait_put(4);
    put_rst_n = 1'b1; get_rst_n = 1'b1;
    wait_put(2);
    check("R1", empty == 1'b1, empty, 1);
    check("R1", full == 1'b0, full, 0);

    // fill without gets: DEPTH-2 then DEPTH-1
    put_mode = 1; put_budget = DEPTH - 2;
    wait_put(DEPTH + 6);
    check("R5", full == 1'b0, full, 0);
    put_budget = 1;
    wait_put(4);
    check("R5", full == 1'b1, full, 1);
    // keep requesting while full
    put_budget = 3;
    wait_put(20);
    check("R2", full == 1'b1, full, 1);
    check("R2", expq.size() == DEPTH - 1, expq.size(), DEPTH - 1);
    check("R2", put_budget == 3, put_budget, 3);
    put_budget = 0;

    // drain: first word out must be the first one in (R1, R4)
    base = received;
    get_mode = 1;
    wait_put(80);
    get_mode = 0;
    wait_put(10);
    check("R6", expq.size() == 1, expq.size(), 1);
    check("R6", empty == 1'b1, empty, 1);
    check("R8", full == 1'b0, full, 0);
    check("R1", received - base == DEPTH - 2, received - base, DEPTH - 2);

    // second word releases the stranded one
    put_budget = 1;
    wait_put(10);
    check("R6", empty == 1'b0, empty, 0);
    base = received;
    get_mode = 1;
    wait_put(30);
    get_mode = 0;
    wait_put(10);
    check("R6", received - base == 1, received - base, 1);
    check("R6", empty == 1'b1, empty, 1);

    // random traffic across many wraps
    base = received;
    put_mode = 2; get_mode = 2;
    wait_put(6000);
    put_mode = 0;
    get_mode = 1;
    wait_put(100);
    get_mode = 0;
    wait_put(10);
    check("R4", received - base > 8 * DEPTH, received - base, 8 * DEPTH);
    check("R6", expq.size() <= 1, expq.size(), 1);
    check("R6", empty == 1'b1, empty, 1);
    check("R8", full == 1'b0, full, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule